// File: doc/BRIEF.md
# Dataflow Grid Instruction Placer

This block sits between an instruction decoder and a two-dimensional array of ALU cells. Instructions arrive one per cycle, in program order. Each grid column belongs to one architectural register and rows are numbered from the top, starting at 0. Data moves only downwards: a cell reads the outputs of the row directly above it. A cell with no instruction passes its column's value down unchanged.

For each instruction the placer picks the highest row at which the instruction still sees correct data. It keeps a small table per column: the row just below the most recent writer of that register, and the deepest row that has read it. It also tracks the memory unit order, the depth of the grid used so far and a branch barrier. With this state, dependent instructions can be placed in the same cycle, independent ones share a row, and a conditional branch divides the grid.

When no row is left, the placer raises a sticky full flag and refuses input until a flush clears all of its state.

Top module: `grid_placer`

## Requirements
- R1: An ALU instruction (kind code 0) is placed in column `in_dst`. Its row is the largest "next row" value among its used sources, where a register's next row is one past the row of its latest writer, or 0 if it has not been written since reset or flush. The barrier of R4 also applies.
- R2: An instruction that writes a register is never placed above the next row of that register's previous writer. It is also never placed above the deepest row where an earlier instruction read that register.
- R3: A conditional branch (kind code 3) is placed one row below the deepest row used by any instruction placed since reset or flush. If nothing has been placed, it goes in row 0.
- R4: Every instruction accepted after a branch is placed at least one row below that branch.
- R5: A load (kind code 1) writes column `in_dst` and takes its address from source A. Loads and stores (kind code 2) use the per-row memory unit. Each memory operation is placed strictly below the previous one.
- R6: For each placed instruction, `out_valid` is high for one cycle on the clock edge after the cycle in which it was accepted. In that cycle `out_row` gives the row, which is less than ROWS, `out_col` equals `in_dst`, and `out_kind` equals `in_kind`.
- R7: If the required row is ROWS or more, the instruction is not placed, `out_valid` stays low, and `full` rises on the next edge. `full` stays high, and every further instruction is ignored, until a flush.
- R8: `flush` clears all column records, the barrier, the depth and the memory order. It also drops `full`. It takes priority over an instruction offered in the same cycle, which is discarded. After a flush, an instruction whose sources were written before the flush is placed in row 0.
- R9: After reset, `full` and `out_valid` are low and all records are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all placement state |
| in_valid | input | 1 | Instruction offered this cycle |
| in_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 branch |
| in_dst | input | $clog2(COLS) | Destination register / column |
| in_src_a | input | $clog2(COLS) | Source register A (address for memory operations) |
| in_use_a | input | 1 | Source A is read |
| in_src_b | input | $clog2(COLS) | Source register B |
| in_use_b | input | 1 | Source B is read |
| out_valid | output | 1 | A placement is reported |
| out_row | output | $clog2(ROWS+1) | Assigned row |
| out_col | output | $clog2(COLS) | Assigned column |
| out_kind | output | 2 | Kind of the placed instruction |
| full | output | 1 | Grid exhausted; input is refused until flush |

## Verification
The hardest case to reach is an overwrite that is held down by an earlier reader rather than an earlier writer. To produce it, a register is read far down the grid and then rewritten by an instruction with no sources. Directed sequences build that chain, together with a branch barrier followed by a memory operation. Random streams with a fixed seed mix all four kinds over a few registers, so records collide often and the grid fills repeatedly; each fill is followed by a flush, sometimes together with an offered instruction.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } gp_kind_e;
endpackage

// File: rtl/gp_col_table.sv
module gp_col_table #(
  parameter int COLS = 8,
  parameter int RW   = 4,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] rd_a,
  input  logic [CW-1:0] rd_b,
  input  logic [CW-1:0] rd_d,
  output logic [RW-1:0] rec_a,
  output logic [RW-1:0] rec_b,
  output logic [RW-1:0] rec_d,
  output logic [RW-1:0] rdfl_d,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_col,
  input  logic [RW-1:0] wr_val,
  input  logic          mk_a_en,
  input  logic [CW-1:0] mk_a,
  input  logic          mk_b_en,
  input  logic [CW-1:0] mk_b,
  input  logic [RW-1:0] mk_row
);
  logic [RW-1:0] rec  [COLS];
  logic [RW-1:0] rdfl [COLS];

  assign rec_a  = rec[rd_a];
  assign rec_b  = rec[rd_b];
  assign rec_d  = rec[rd_d];
  assign rdfl_d = rdfl[rd_d];

  always_ff @(posedge clk) begin
    for (int c = 0; c < COLS; c++) begin
      if (rst || flush) begin
        rec[c]  <= '0;
        rdfl[c] <= '0;
      end else begin
        if (wr_en && wr_col == CW'(c))
          rec[c] <= wr_val;
        if (((mk_a_en && mk_a == CW'(c)) || (mk_b_en && mk_b == CW'(c))) &&
            mk_row > rdfl[c])
          rdfl[c] <= mk_row;
      end
    end
  end

  // R2: each new writer of a column lands strictly below the previous writer
  p_rec_grows_r2: assert property (@(posedge clk) disable iff (rst || flush)
    wr_en |-> wr_val > rec[wr_col]);

  // R2: a column's reader floor never moves up
  p_rdfl_mono_r2: assert property (@(posedge clk) disable iff (rst || flush)
    1'b1 |=> rdfl[$past(rd_d)] >= $past(rdfl_d));
endmodule

// File: rtl/gp_row_calc.sv
module gp_row_calc
  import gp_pkg::*;
#(
  parameter int RW = 4
) (
  input  gp_kind_e      kind,
  input  logic          use_a,
  input  logic          use_b,
  input  logic [RW-1:0] rec_a,
  input  logic [RW-1:0] rec_b,
  input  logic [RW-1:0] rec_d,
  input  logic [RW-1:0] rdfl_d,
  input  logic [RW-1:0] barrier,
  input  logic [RW-1:0] mem_next,
  input  logic [RW-1:0] depth,
  output logic [RW-1:0] row
);
  function automatic logic [RW-1:0] vmax(logic [RW-1:0] x, logic [RW-1:0] y);
    return (x > y) ? x : y;
  endfunction

  logic writes, is_mem;
  assign writes = (kind == K_ALU) || (kind == K_LOAD);
  assign is_mem = (kind == K_LOAD) || (kind == K_STORE);

  always_comb begin
    row = barrier;
    if (use_a)  row = vmax(row, rec_a);
    if (use_b)  row = vmax(row, rec_b);
    if (writes) row = vmax(row, vmax(rec_d, rdfl_d));
    if (is_mem) row = vmax(row, mem_next);
    if (kind == K_BRANCH) row = depth;
  end
endmodule

// File: rtl/grid_placer.sv
module grid_placer
  import gp_pkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [1:0]    in_kind,
  input  logic [CW-1:0] in_dst,
  input  logic [CW-1:0] in_src_a,
  input  logic          in_use_a,
  input  logic [CW-1:0] in_src_b,
  input  logic          in_use_b,
  output logic          out_valid,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic [1:0]    out_kind,
  output logic          full
);
  gp_kind_e      kind;
  logic [RW-1:0] rec_a, rec_b, rec_d, rdfl_d;
  logic [RW-1:0] barrier, mem_next, depth, row, row_nx;
  logic          accept, fits, place, writes, is_mem;

  assign kind   = gp_kind_e'(in_kind);
  assign writes = (kind == K_ALU) || (kind == K_LOAD);
  assign is_mem = (kind == K_LOAD) || (kind == K_STORE);
  assign accept = in_valid && !full && !flush;
  assign fits   = row < RW'(ROWS);
  assign place  = accept && fits;
  assign row_nx = row + 1'b1;

  gp_col_table #(.COLS(COLS), .RW(RW), .CW(CW)) u_tab (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_a(in_src_a), .rd_b(in_src_b), .rd_d(in_dst),
    .rec_a(rec_a), .rec_b(rec_b), .rec_d(rec_d), .rdfl_d(rdfl_d),
    .wr_en(place && writes), .wr_col(in_dst), .wr_val(row_nx),
    .mk_a_en(place && in_use_a), .mk_a(in_src_a),
    .mk_b_en(place && in_use_b), .mk_b(in_src_b),
    .mk_row(row)
  );

  gp_row_calc #(.RW(RW)) u_calc (
    .kind(kind), .use_a(in_use_a), .use_b(in_use_b),
    .rec_a(rec_a), .rec_b(rec_b), .rec_d(rec_d), .rdfl_d(rdfl_d),
    .barrier(barrier), .mem_next(mem_next), .depth(depth),
    .row(row)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      barrier   <= '0;
      mem_next  <= '0;
      depth     <= '0;
      full      <= 1'b0;
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_kind  <= '0;
    end else begin
      out_valid <= place;
      if (place) begin
        out_row  <= row;
        out_col  <= in_dst;
        out_kind <= in_kind;
        if (row_nx > depth) depth <= row_nx;
        if (is_mem) mem_next <= row_nx;
        if (kind == K_BRANCH) barrier <= row_nx;
      end
      if (accept && !fits) full <= 1'b1;
    end
  end

  // R7: full holds until a flush
  p_full_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    full && !flush |=> full);

  // R7: nothing is reported while full
  p_no_out_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    full && !flush |=> !out_valid);

  // R8: flush wins over an offered instruction
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !full && !out_valid);

  // R6: reported rows lie inside the grid
  p_row_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_row < RW'(ROWS));

  // R4: the barrier never moves up without a flush
  p_barrier_mono_r4: assert property (@(posedge clk) disable iff (rst)
    !flush |=> barrier >= $past(barrier));

  // R4: placements after a branch stay below it
  p_after_branch_r4: assert property (@(posedge clk) disable iff (rst || flush)
    place && kind != K_BRANCH |-> row >= barrier);

  // R5: memory operations keep strict row order
  p_mem_order_r5: assert property (@(posedge clk) disable iff (rst || flush)
    place && is_mem |-> row >= mem_next);

  // R3: a branch never lands above any earlier placement
  p_branch_depth_r3: assert property (@(posedge clk) disable iff (rst || flush)
    place && kind == K_BRANCH |-> row >= barrier && row >= mem_next);
endmodule

// File: tb/grid_placer_test.sv
`timescale 1ns/1ps
module grid_placer_test;
  localparam int COLS = 8;
  localparam int ROWS = 8;
  localparam int CW = 3;
  localparam int RW = 4;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0, in_valid = 1'b0;
  logic [1:0] in_kind = '0;
  logic [CW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic in_use_a = 1'b0, in_use_b = 1'b0;
  logic out_valid, full;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;
  logic [1:0] out_kind;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  int m_rec [COLS];
  int m_rdfl [COLS];
  int m_mem, m_depth, m_bar;
  bit m_full;

  always #2.5 clk = ~clk;

  grid_placer #(.COLS(COLS), .ROWS(ROWS)) uut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_kind(in_kind), .in_dst(in_dst), .in_src_a(in_src_a),
    .in_use_a(in_use_a), .in_src_b(in_src_b), .in_use_b(in_use_b),
    .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
    .out_kind(out_kind), .full(full));

  task automatic check_eq(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < COLS; c++) begin m_rec[c] = 0; m_rdfl[c] = 0; end
    m_mem = 0; m_depth = 0; m_bar = 0; m_full = 0;
  endtask

  function automatic int imax(int x, int y);
    return (x > y) ? x : y;
  endfunction

  function automatic int mrow(int k, int d, int a, bit ua, int b, bit ub);
    int r;
    if (k == 3) return m_depth;
    r = m_bar;
    if (ua) r = imax(r, m_rec[a]);
    if (ub) r = imax(r, m_rec[b]);
    if (k <= 1) r = imax(r, imax(m_rec[d], m_rdfl[d]));
    if (k == 1 || k == 2) r = imax(r, m_mem);
    return r;
  endfunction

  task automatic issue(int k, int d, int a, bit ua, int b, bit ub, string tag);
    int r;
    in_valid = 1'b1; in_kind = 2'(k); in_dst = CW'(d);
    in_src_a = CW'(a); in_use_a = ua; in_src_b = CW'(b); in_use_b = ub;
    @(negedge clk);
    in_valid = 1'b0;
    if (m_full) begin
      check_eq(int'(out_valid), 0, "R7", "ignored while full out_valid");
      check_eq(int'(full), 1, "R7", "full held");
    end else begin
      r = mrow(k, d, a, ua, b, ub);
      if (r >= ROWS) begin
        m_full = 1;
        check_eq(int'(out_valid), 0, "R7", "overflow out_valid");
        check_eq(int'(full), 1, "R7", "overflow full");
      end else begin
        check_eq(int'(out_valid), 1, "R6", "out_valid");
        check_eq(int'(out_row), r, tag, "out_row");
        check_eq(int'(out_col), d, "R6", "out_col");
        check_eq(int'(out_kind), k, "R6", "out_kind");
        if (k <= 1) m_rec[d] = r + 1;
        if (ua) m_rdfl[a] = imax(m_rdfl[a], r);
        if (ub) m_rdfl[b] = imax(m_rdfl[b], r);
        if (k == 1 || k == 2) m_mem = r + 1;
        if (k == 3) m_bar = r + 1;
        m_depth = imax(m_depth, r + 1);
      end
    end
  endtask

  task automatic do_flush(bit with_instr);
    flush = 1'b1;
    in_valid = with_instr; in_kind = 2'd0; in_dst = 3'd1; in_use_a = 1'b0; in_use_b = 1'b0;
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    check_eq(int'(full), 0, "R8", "full after flush");
    check_eq(int'(out_valid), 0, "R8", "out_valid after flush");
    model_clear();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq(int'(full), 0, "R9", "reset full");
    check_eq(int'(out_valid), 0, "R9", "reset out_valid");

    // summing loop: three inits, load, adds, branch, tail
    issue(0, 1, 0, 0, 0, 0, "R1");
    issue(0, 2, 0, 0, 0, 0, "R1");
    issue(0, 3, 0, 0, 0, 0, "R1");
    issue(1, 4, 2, 1, 0, 0, "R5");   // row 1
    issue(0, 3, 3, 1, 4, 1, "R1");   // row 2
    issue(0, 2, 2, 1, 0, 0, "R2");   // row 1, reader floor of R2
    issue(0, 1, 1, 1, 0, 0, "R1");   // row 1
    issue(3, 0, 1, 1, 0, 0, "R3");   // row 3
    issue(0, 3, 1, 1, 3, 1, "R4");   // row 4
    check_eq(int'(out_row), 4, "R4", "tail below branch");

    // overwrite held down by a distant reader
    do_flush(0);
    issue(0, 1, 0, 1, 0, 0, "R1");   // 0
    issue(0, 2, 1, 1, 0, 0, "R1");   // 1
    issue(0, 3, 2, 1, 0, 0, "R1");   // 2
    issue(0, 4, 0, 1, 3, 1, "R1");   // 3, reads R0
    issue(0, 0, 0, 0, 0, 0, "R2");   // 3 from reader floor
    check_eq(int'(out_row), 3, "R2", "WAR floor");
    issue(2, 0, 3, 1, 4, 1, "R5");   // 4
    issue(2, 0, 5, 1, 0, 0, "R5");   // 5 by memory order
    check_eq(int'(out_row), 5, "R5", "memory order");

    // fill the grid, then ignore, then flush with an offered instruction
    do_flush(0);
    for (int i = 0; i < ROWS + 1; i++) issue(0, 1, 1, 1, 0, 0, "R1");
    issue(0, 2, 0, 0, 0, 0, "R7");
    do_flush(1);
    issue(0, 1, 1, 1, 0, 0, "R8");
    check_eq(int'(out_row), 0, "R8", "record cleared");

    // branch with nothing placed
    do_flush(0);
    issue(3, 0, 2, 1, 0, 0, "R3");
    check_eq(int'(out_row), 0, "R3", "empty-grid branch");

    // random streams
    for (int i = 0; i < 3000; i++) begin
      int k, w;
      w = int'($urandom_range(0, 9));
      k = (w < 5) ? 0 : (w < 7) ? 1 : (w < 9) ? 2 : 3;
      issue(k, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 1'($urandom),
            int'($urandom_range(0, 3)), 1'($urandom), "R1");
      if (m_full && ($urandom_range(0, 2) == 0)) do_flush(1'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule